// File: doc/BRIEF.md
# Machine State Register Control Unit

This unit owns the 64-bit machine state register of a processor core and applies every architected change to it. Interrupt entry, return from interrupt, move-to (in two widths selected by an instruction field) and move-from are all handled here. Each of these updates copies its own subset of fields. After a move-to or a return, a fixup step enables translation and external interrupts whenever the result is in problem state.

The unit also screens each incoming instruction for privilege. While the problem-state bit (PR) is set, it rejects privileged instructions, special-register moves that name a privileged register, and moves to or from unimplemented registers. A rejected instruction moves a two-state controller from `ST_READY` to `ST_DELIVER`. That raises a one-cycle program-interrupt request and performs interrupt entry on the way back to `ST_READY`, the only transition out of `ST_DELIVER`. The pre-entry register value is presented on a save output for the second save/restore register.

Instruction class codes on `op_class` are: 0 ordinary, 1 other privileged, 2 move-to, 3 move-from, 4 return, 5 special-register write, 6 special-register read, 7 interrupt entry. Bit positions use little-endian numbering: SF=63, HV=60, EE=15, PR=14, ME=12, IR=5, DR=4, RI=1, LE=0.

Top module: `msr_ctrl_unit`

## Requirements
- R1: After reset the register reads 64'h8000_0000_0000_0001 (only SF and LE set), with no interrupt request, read strobe or keep strobe active.
- R2: Class 7 accepted in `ST_READY` sets SF and LE, clears PR, IR, DR and RI, and keeps every other bit. On the following cycle `save_out` holds the value from before the entry.
- R3: Class 4 (return) copies bits 63, 60, 15, 14, 12, 5, 4, 1 and 0 from `saved_state` and leaves all other bits unchanged.
- R4: Class 2 with instruction bit 16 set copies only EE (bit 15) and RI (bit 1) from `operand`.
- R5: Class 2 with instruction bit 16 clear copies every bit from `operand` except HV, ME and LE, which keep their value.
- R6: After class 2 or class 4, if the resulting PR is 1 then EE, IR and DR are also 1.
- R7: Class 3 makes `rd_valid` high for one cycle on the cycle after acceptance, with `rd_data` equal to the full register.
- R8: With PR=1, classes 1 to 4, and classes 5 and 6 with instruction bit 20 set, move to `ST_DELIVER`. On the next cycle `prog_irq` is high and the register is unchanged. One cycle later `prog_irq` is low, interrupt entry has been applied, and `save_out` holds the value from before the trap.
- R9: With PR=1, class 5 or 6 with `spr_impl` low traps as in R8. With PR=0, class 6 with `spr_impl` low pulses `rd_keep` for one cycle and class 5 with `spr_impl` low has no effect.
- R10: Operations presented while in `ST_DELIVER` are dropped. The register after delivery equals the interrupt-entry value of the trapped state.
- R11: Class 0, and classes 5 or 6 that do not trap, leave the register unchanged and raise no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_class | input | 3 | Instruction class code |
| insn_word | input | 32 | Raw instruction word (bit 16 move width, bit 20 register privilege) |
| operand | input | 64 | Source value for move-to |
| saved_state | input | 64 | Saved state value used by return |
| spr_impl | input | 1 | Named special register is implemented |
| msr_out | output | 64 | Current register value |
| save_out | output | 64 | Pre-entry value for the second save/restore register |
| rd_data | output | 64 | Move-from result |
| rd_valid | output | 1 | `rd_data` is valid |
| rd_keep | output | 1 | Destination must keep its old value |
| prog_irq | output | 1 | Privileged-type program interrupt request |

## Verification
The properties assume that `op_class` carries one of the eight defined codes and that `spr_impl` and instruction bits 16 and 20 are meaningful whenever `op_valid` is high. They also assume that a new operation may arrive in any cycle, including during delivery. The stimulus pulses `op_valid` for single cycles and only uses defined class codes. It deliberately presents a return while a trap is being delivered, so the drop rule is exercised under a legal input pattern.

// File: rtl/msr_pkg.sv
package msr_pkg;

    localparam int MSR_W  = 64;
    localparam int POS_SF = 63;
    localparam int POS_HV = 60;
    localparam int POS_EE = 15;
    localparam int POS_PR = 14;
    localparam int POS_ME = 12;
    localparam int POS_IR = 5;
    localparam int POS_DR = 4;
    localparam int POS_RI = 1;
    localparam int POS_LE = 0;

    localparam logic [MSR_W-1:0] ONE  = {{(MSR_W-1){1'b0}}, 1'b1};
    localparam logic [MSR_W-1:0] M_SF = ONE << POS_SF;
    localparam logic [MSR_W-1:0] M_HV = ONE << POS_HV;
    localparam logic [MSR_W-1:0] M_EE = ONE << POS_EE;
    localparam logic [MSR_W-1:0] M_PR = ONE << POS_PR;
    localparam logic [MSR_W-1:0] M_ME = ONE << POS_ME;
    localparam logic [MSR_W-1:0] M_IR = ONE << POS_IR;
    localparam logic [MSR_W-1:0] M_DR = ONE << POS_DR;
    localparam logic [MSR_W-1:0] M_RI = ONE << POS_RI;
    localparam logic [MSR_W-1:0] M_LE = ONE << POS_LE;

    // derived field groups
    localparam logic [MSR_W-1:0] M_ENTRY_SET = M_SF | M_LE;
    localparam logic [MSR_W-1:0] M_ENTRY_CLR = M_PR | M_IR | M_DR | M_RI;
    localparam logic [MSR_W-1:0] M_RESET     = M_SF | M_LE;
    localparam logic [MSR_W-1:0] M_RET       = M_SF | M_HV | M_EE | M_PR | M_ME
                                             | M_IR | M_DR | M_RI | M_LE;
    localparam logic [MSR_W-1:0] M_MT_KEEP   = M_HV | M_ME | M_LE;
    localparam logic [MSR_W-1:0] M_MT_L1     = M_EE | M_RI;
    localparam logic [MSR_W-1:0] M_FIX       = M_EE | M_IR | M_DR;

    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_PRIV     = 3'd1,
        OP_MTMSR    = 3'd2,
        OP_MFMSR    = 3'd3,
        OP_RFI      = 3'd4,
        OP_MTSPR    = 3'd5,
        OP_MFSPR    = 3'd6,
        OP_TAKE_INT = 3'd7
    } op_class_e;

    typedef enum logic {
        ST_READY   = 1'b0,
        ST_DELIVER = 1'b1
    } ctrl_state_e;

endpackage

// File: rtl/msr_priv_check.sv
module msr_priv_check
    import msr_pkg::*;
(
    input  logic      pr,
    input  op_class_e op,
    input  logic      spr_priv_bit,
    input  logic      spr_impl,
    output logic      trap
);
    logic needs_priv;

    always_comb begin
        needs_priv = 1'b0;
        unique case (op)
            OP_PRIV, OP_MTMSR, OP_MFMSR, OP_RFI: needs_priv = 1'b1;
            OP_MTSPR, OP_MFSPR:                  needs_priv = spr_priv_bit | ~spr_impl;
            default:                             needs_priv = 1'b0;
        endcase
    end

    assign trap = pr & needs_priv;
endmodule

// File: rtl/msr_next_calc.sv
module msr_next_calc
    import msr_pkg::*;
(
    input  logic [MSR_W-1:0] cur,
    input  op_class_e        op,
    input  logic             l_bit,
    input  logic [MSR_W-1:0] operand,
    input  logic [MSR_W-1:0] saved,
    output logic [MSR_W-1:0] nxt,
    output logic [MSR_W-1:0] entry_val,
    output logic             upd
);
    logic [MSR_W-1:0] raw;
    logic             fix_en;

    assign entry_val = (cur | M_ENTRY_SET) & ~M_ENTRY_CLR;

    always_comb begin
        raw    = cur;
        upd    = 1'b0;
        fix_en = 1'b0;
        unique case (op)
            OP_MTMSR: begin
                upd    = 1'b1;
                fix_en = 1'b1;
                if (l_bit)
                    raw = (cur & ~M_MT_L1) | (operand & M_MT_L1);
                else
                    raw = (cur & M_MT_KEEP) | (operand & ~M_MT_KEEP);
            end
            OP_RFI: begin
                upd    = 1'b1;
                fix_en = 1'b1;
                raw    = (cur & ~M_RET) | (saved & M_RET);
            end
            OP_TAKE_INT: begin
                upd = 1'b1;
                raw = entry_val;
            end
            default: begin
                raw = cur;
            end
        endcase
        nxt = (fix_en && raw[POS_PR]) ? (raw | M_FIX) : raw;
    end
endmodule

// File: rtl/msr_ctrl_unit.sv
module msr_ctrl_unit
    import msr_pkg::*;
#(
    parameter int INSN_W       = 32,
    parameter int SPR_PRIV_POS = 20,
    parameter int MT_L_POS     = 16
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_class,
    input  logic [INSN_W-1:0] insn_word,
    input  logic [63:0]       operand,
    input  logic [63:0]       saved_state,
    input  logic              spr_impl,
    output logic [63:0]       msr_out,
    output logic [63:0]       save_out,
    output logic [63:0]       rd_data,
    output logic              rd_valid,
    output logic              rd_keep,
    output logic              prog_irq
);
    ctrl_state_e      state_q, state_d;
    op_class_e        op_e;
    logic             ready_w;
    logic             accept;
    logic             trap;
    logic             upd;
    logic [MSR_W-1:0] nxt_val;
    logic [MSR_W-1:0] entry_val;
    logic             unused_insn_bits;

    assign op_e    = op_class_e'(op_class);
    assign ready_w = (state_q == ST_READY);
    assign accept  = ready_w & op_valid;

    assign unused_insn_bits = ^insn_word;

    msr_priv_check u_priv (
        .pr           (msr_out[POS_PR]),
        .op           (op_e),
        .spr_priv_bit (insn_word[SPR_PRIV_POS]),
        .spr_impl     (spr_impl),
        .trap         (trap)
    );

    msr_next_calc u_calc (
        .cur       (msr_out),
        .op        (op_e),
        .l_bit     (insn_word[MT_L_POS]),
        .operand   (operand),
        .saved     (saved_state),
        .nxt       (nxt_val),
        .entry_val (entry_val),
        .upd       (upd)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY:   if (accept && trap) state_d = ST_DELIVER;
            ST_DELIVER: state_d = ST_READY;
            default:    state_d = ST_READY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= state_d;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msr_out  <= M_RESET;
            save_out <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
            rd_keep  <= 1'b0;
            prog_irq <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            rd_keep  <= 1'b0;
            prog_irq <= 1'b0;
            unique case (state_q)
                ST_DELIVER: begin
                    msr_out  <= entry_val;
                    save_out <= msr_out;
                end
                ST_READY: begin
                    if (accept && trap) begin
                        prog_irq <= 1'b1;
                    end else if (accept) begin
                        if (upd) msr_out <= nxt_val;
                        if (op_e == OP_TAKE_INT) save_out <= msr_out;
                        if (op_e == OP_MFMSR) begin
                            rd_valid <= 1'b1;
                            rd_data  <= msr_out;
                        end
                        if (op_e == OP_MFSPR && !spr_impl) rd_keep <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/msr_ctrl_chk.sv
module msr_ctrl_chk
    import msr_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        ready,
    input logic        op_valid,
    input logic [2:0]  op_class,
    input logic        l_bit,
    input logic [63:0] msr_out,
    input logic [63:0] save_out,
    input logic        prog_irq,
    input logic        rd_keep
);
    logic take_int, user_mt, l1_mt;
    assign take_int = ready && op_valid && (op_class == OP_TAKE_INT);
    assign user_mt  = ready && op_valid && (op_class == OP_MTMSR) && msr_out[POS_PR];
    assign l1_mt    = ready && op_valid && (op_class == OP_MTMSR) && l_bit && !msr_out[POS_PR];

    AST_ENTRY_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        take_int |=> (msr_out[POS_SF] && msr_out[POS_LE] && !msr_out[POS_PR]
                      && !msr_out[POS_IR] && !msr_out[POS_DR] && !msr_out[POS_RI])); // R2
    AST_ENTRY_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        take_int |=> (save_out == $past(msr_out))); // R2
    AST_MT_NARROW_SCOPE: assert property (@(posedge clk) disable iff (!rst_n)
        l1_mt |=> ((msr_out & ~M_MT_L1) == ($past(msr_out) & ~M_MT_L1))); // R4
    AST_PROBLEM_FIXUP: assert property (@(posedge clk) disable iff (!rst_n)
        msr_out[POS_PR] |-> (msr_out[POS_EE] && msr_out[POS_IR] && msr_out[POS_DR])); // R6
    AST_USER_MT_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        user_mt |=> prog_irq); // R8
    AST_TRAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        prog_irq |=> !prog_irq); // R8
    AST_KEEP_ONLY_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
        rd_keep |-> !msr_out[POS_PR]); // R9
    AST_DELIVER_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        prog_irq |=> (!msr_out[POS_PR] && save_out == $past(msr_out))); // R10
endmodule

bind msr_ctrl_unit msr_ctrl_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ready    (ready_w),
    .op_valid (op_valid),
    .op_class (op_class),
    .l_bit    (insn_word[MT_L_POS]),
    .msr_out  (msr_out),
    .save_out (save_out),
    .prog_irq (prog_irq),
    .rd_keep  (rd_keep)
);

// File: tb/msr_ctrl_unit_tb_top.sv
`timescale 1ns/1ps
module msr_ctrl_unit_tb_top;
    import msr_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [2:0]  op_class;
    logic [31:0] insn_word;
    logic [63:0] operand, saved_state;
    logic        spr_impl;
    logic [63:0] msr_out, save_out, rd_data;
    logic        rd_valid, rd_keep, prog_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    msr_ctrl_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_class(op_class),
        .insn_word(insn_word), .operand(operand), .saved_state(saved_state),
        .spr_impl(spr_impl), .msr_out(msr_out), .save_out(save_out),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_keep(rd_keep), .prog_irq(prog_irq)
    );

    localparam logic [63:0] RST_V  = 64'h8000_0000_0000_0001;
    localparam logic [63:0] PR_PRE = 64'h8000_0000_0000_4001;
    localparam logic [31:0] I_L1   = 32'h0001_0000;
    localparam logic [31:0] I_B20  = 32'h0010_0000;

    typedef struct packed {
        logic [63:0] pre;
        logic [2:0]  cls;
        logic [31:0] insn;
        logic [63:0] opnd;
        logic [63:0] sav;
        logic        impl;
        logic        trap;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VECS [NVEC] = '{
        '{RST_V,  3'd2, 32'h0, 64'h0000_0000_0000_8032, 64'h0, 1'b1, 1'b0}, // R5
        '{RST_V,  3'd2, I_L1,  64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1, 1'b0}, // R4
        '{PR_PRE, 3'd2, 32'h0, 64'h0, 64'h0, 1'b1, 1'b1},                   // R8
        '{RST_V,  3'd4, 32'h0, 64'h0, 64'h9000_0000_0000_5000, 1'b1, 1'b0}, // R3 R6
        '{PR_PRE, 3'd3, 32'h0, 64'h0, 64'h0, 1'b1, 1'b1},                   // R8
        '{PR_PRE, 3'd5, 32'h0, 64'h0, 64'h0, 1'b1, 1'b0},                   // R11
        '{PR_PRE, 3'd5, I_B20, 64'h0, 64'h0, 1'b1, 1'b1},                   // R8
        '{PR_PRE, 3'd6, 32'h0, 64'h0, 64'h0, 1'b0, 1'b1},                   // R9
        '{RST_V,  3'd6, I_B20, 64'h0, 64'h0, 1'b1, 1'b0},                   // R11
        '{PR_PRE, 3'd1, 32'h0, 64'h0, 64'h0, 1'b1, 1'b1},                   // R8
        '{PR_PRE, 3'd0, 32'h0, 64'h0, 64'h0, 1'b1, 1'b0},                   // R11
        '{64'h8000_0000_0000_8033, 3'd7, 32'h0, 64'h0, 64'h0, 1'b1, 1'b0},  // R2
        '{PR_PRE, 3'd7, 32'h0, 64'h0, 64'h0, 1'b1, 1'b0},                   // R2
        '{RST_V,  3'd2, 32'h0, 64'h0000_0000_0000_4000, 64'h0, 1'b1, 1'b0}, // R6
        '{PR_PRE, 3'd4, 32'h0, 64'h0, 64'h0, 1'b1, 1'b1}                    // R8
    };

    function automatic logic [63:0] fixup(input logic [63:0] m);
        return m[14] ? (m | 64'h0000_0000_0000_8030) : m;
    endfunction

    function automatic logic [63:0] m_entry(input logic [63:0] m);
        return (m | 64'h8000_0000_0000_0001) & ~64'h0000_0000_0000_4032;
    endfunction

    function automatic logic [63:0] m_apply(input logic [63:0] m, input logic [2:0] c,
                                            input logic [31:0] ins, input logic [63:0] opd,
                                            input logic [63:0] sv);
        logic [63:0] retm, keep, l1;
        retm = 64'h9000_0000_0000_D033;
        keep = 64'h1000_0000_0000_1001;
        l1   = 64'h0000_0000_0000_8002;
        case (c)
            3'd2:    return ins[16] ? fixup((m & ~l1) | (opd & l1))
                                    : fixup((m & keep) | (opd & ~keep));
            3'd4:    return fixup((m & ~retm) | (sv & retm));
            3'd7:    return m_entry(m);
            default: return m;
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; op_valid = 1'b0; op_class = 3'd0; insn_word = '0;
        operand = '0; saved_state = '0; spr_impl = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // present at a negedge, outputs reflect the following posedge at the next negedge
    task automatic issue(input logic [2:0] c, input logic [31:0] ins,
                         input logic [63:0] opd, input logic [63:0] sv, input logic impl);
        op_valid = 1'b1; op_class = c; insn_word = ins;
        operand = opd; saved_state = sv; spr_impl = impl;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] m0, m1;

        // R1 reset state
        do_reset();
        check("R1 msr", msr_out, RST_V);
        check("R1 irq", {63'h0, prog_irq}, 64'h0);
        check("R1 rd_valid", {63'h0, rd_valid}, 64'h0);
        check("R1 rd_keep", {63'h0, rd_keep}, 64'h0);

        for (int i = 0; i < NVEC; i++) begin
            do_reset();
            issue(3'd4, 32'h0, 64'h0, VECS[i].pre, 1'b1);
            m0 = m_apply(RST_V, 3'd4, 32'h0, 64'h0, VECS[i].pre);
            check("R3 preset", msr_out, m0);
            issue(VECS[i].cls, VECS[i].insn, VECS[i].opnd, VECS[i].sav, VECS[i].impl);
            check("R8 irq flag", {63'h0, prog_irq}, {63'h0, VECS[i].trap});
            if (VECS[i].trap) begin
                check("R8 msr held", msr_out, m0);
                @(negedge clk);
                check("R8 entry", msr_out, m_entry(m0));
                check("R8 save", save_out, m0);
                check("R8 irq drop", {63'h0, prog_irq}, 64'h0);
            end else begin
                check("R11 R2 R3 R4 R5 R6 result", msr_out,
                      m_apply(m0, VECS[i].cls, VECS[i].insn, VECS[i].opnd, VECS[i].sav));
                if (VECS[i].cls == 3'd7) check("R2 save", save_out, m0);
            end
        end

        // R7 move-from, then R3 partial field kept by return
        do_reset();
        issue(3'd2, 32'h0, 64'h8000_0000_0000_A002, 64'h0, 1'b1);
        check("R5 setup", msr_out, 64'h8000_0000_0000_A003);
        issue(3'd3, 32'h0, 64'h0, 64'h0, 1'b1);
        check("R7 valid", {63'h0, rd_valid}, 64'h1);
        check("R7 data", rd_data, 64'h8000_0000_0000_A003);
        @(negedge clk);
        check("R7 one cycle", {63'h0, rd_valid}, 64'h0);
        issue(3'd4, 32'h0, 64'h0, 64'h0, 1'b1);
        check("R3 partial kept", msr_out, 64'h0000_0000_0000_2000);

        // R9 unimplemented register in privileged state
        do_reset();
        issue(3'd6, 32'h0, 64'h0, 64'h0, 1'b0);
        check("R9 keep", {63'h0, rd_keep}, 64'h1);
        check("R9 msr", msr_out, RST_V);
        @(negedge clk);
        check("R9 keep pulse", {63'h0, rd_keep}, 64'h0);
        issue(3'd5, 32'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0);
        check("R9 write no effect", msr_out, RST_V);
        check("R9 no irq", {63'h0, prog_irq}, 64'h0);

        // R10 operation during delivery is dropped
        do_reset();
        issue(3'd4, 32'h0, 64'h0, PR_PRE, 1'b1);
        m1 = msr_out;
        issue(3'd2, 32'h0, 64'h0, 64'h0, 1'b1);
        check("R10 irq", {63'h0, prog_irq}, 64'h1);
        issue(3'd4, 32'h0, 64'h0, 64'h0, 1'b1);
        check("R10 entry only", msr_out, m_entry(m1));
        @(negedge clk);
        check("R10 stable", msr_out, m_entry(m1));
        check("R10 no second irq", {63'h0, prog_irq}, 64'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule